// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block turns word accesses into the strobe and address sequences of a DRAM with multiplexed address pins. A requester presents an area number, a halfword address, a direction and two byte enables, and holds them until `rdy_o` is seen high. The controller splits the address into a row part and a column part according to a programmable column width of 8, 9 or 10 bits. It drives the row on the shared address pins while RAS falls. It then drives the column while the upper and lower CAS strobes fall, one per selected byte lane.

After an access the row stays open: RAS stays low and CAS returns high. A later access to the same area and row needs only one column cycle. Any other access first returns RAS high for a precharge cycle. A periodic tick requests refresh. The refresh is done as CAS-before-RAS. If the self-refresh input is high when the refresh starts, the strobes stay low until that input drops. Refresh wins over an access that arrives in the same cycle, and an open row is closed before the refresh begins.

Top module: `dram_ctrl`

## Requirements
- R1: Only areas 2, 3, 4 and 5 are served. A request that names any other area produces no strobe change and no `rdy_o`, and leaves an open row open.
- R2: An access accepted while no row is open produces, from the next cycle on: one cycle with all strobes high, one row cycle, then one column cycle with `rdy_o` high. After that RAS stays low and both CAS stay high.
- R3: With `addr_i` as a halfword address and `col_sel_i` = 0, 1, 2 or 3 selecting 8, 9, 10 or 10 column bits, the column is the low column-width bits of `addr_i` and the row is the remaining upper bits. `ma_o` carries the low `MA_W` row bits in the row cycle and the zero-extended column in the column cycle.
- R4: In the column cycle `ucas_n_o` is low exactly when `be_i[1]` was set, and `lcas_n_o` is low exactly when `be_i[0]` was set. A request with both enables clear is ignored.
- R5: `we_n_o` is low only in the column cycle of a write (`we_i` = 1), and is high at all other times.
- R6: While a row is open, an access with the same area and the same row gets its column cycle in the very next cycle, and RAS stays low throughout.
- R7: While a row is open, an access to a different row or area first drives all strobes high for one cycle, then runs the row and column cycles.
- R8: With no row open, a refresh runs as follows: both CAS low with RAS high for one cycle, then RAS low as well for one cycle, then all strobes high for one cycle, then idle with no row open.
- R9: A refresh request and an access in the same cycle are served refresh first. If a row is open, one all-high cycle comes before CAS falls.
- R10: A refresh tick that arrives while a sequence is running is kept and served at the next point where a new sequence may start.
- R11: If `self_ref_i` is high when a refresh starts, RAS and both CAS stay low after RAS falls for as long as `self_ref_i` stays high. When it drops, one all-high cycle follows, then idle.
- R12: During and right after reset all strobes and `we_n_o` are high, `rdy_o` is low, and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until `rdy_o` is seen |
| area_i | input | 3 | Area number of the request |
| addr_i | input | ADDR_W | Halfword address |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| col_sel_i | input | 2 | Column width select: 0 = 8, 1 = 9, 2 or 3 = 10 bits |
| ref_tick_i | input | 1 | Refresh request tick |
| self_ref_i | input | 1 | Selects self-refresh for a refresh that starts |
| ma_o | output | MA_W | Multiplexed row/column address |
| ras_n_o | output | 1 | Row strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| rdy_o | output | 1 | Column cycle of the current access |

## Verification
A refresh tick and an access request can land in the same cycle. This happens both when no row is open and when a row is open, and the refresh must win in both cases. The bench raises the tick and the request on the same clock, both from idle and from an open row. A behavioural model built on a queue of expected strobe states gives the expected order: the close cycle if a row was open, the refresh with CAS leading RAS, the recovery cycle, and then the full row and column sequence of the delayed access. Every cycle of the strobes, `ma_o` and `rdy_o` is compared against that order. A tick that arrives in the middle of an access is also checked: it must be served only after that access.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  localparam int unsigned COL_MIN = 8;
  localparam int unsigned COL_MAX = 10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ROW, ST_COL, ST_OPEN,
    ST_CLOSE, ST_RCAS, ST_RRAS, ST_SELF, ST_RPRE
  } dram_st_e;

  function automatic int unsigned col_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    col_bits = 8;
      2'd1:    col_bits = 9;
      default: col_bits = 10;
    endcase
  endfunction
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned MA_W   = 10,
  localparam int unsigned ROW_W = ADDR_W - COL_MIN
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        col_sel_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [MA_W-1:0]   col_o
);
  logic [MA_W-1:0] col_mask;

  always_comb begin
    col_mask = MA_W'((1 << col_bits(col_sel_i)) - 1);
    col_o    = addr_i[MA_W-1:0] & col_mask;
    case (col_sel_i)
      2'd0:    row_o = addr_i[ADDR_W-1:8];
      2'd1:    row_o = {1'b0, addr_i[ADDR_W-1:9]};
      default: row_o = {2'b00, addr_i[ADDR_W-1:10]};
    endcase
  end
endmodule

// File: rtl/dram_page_trk.sv
module dram_page_trk #(
  parameter int unsigned ROW_W = 15,
  parameter int unsigned MA_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [MA_W-1:0]  col_i,
  input  logic [2:0]       area_i,
  input  logic [1:0]       be_i,
  input  logic             we_i,
  output logic [ROW_W-1:0] row_o,
  output logic [MA_W-1:0]  col_o,
  output logic [1:0]       be_o,
  output logic             we_o,
  output logic             hit_o
);
  logic [2:0] area_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o  <= '0;
      col_o  <= '0;
      area_q <= '0;
      be_o   <= '0;
      we_o   <= 1'b0;
    end else if (accept_i) begin
      row_o  <= row_i;
      col_o  <= col_i;
      area_q <= area_i;
      be_o   <= be_i;
      we_o   <= we_i;
    end
  end

  assign hit_o = (area_i == area_q) && (row_i == row_o);
endmodule

// File: rtl/dram_ref_req.sv
module dram_ref_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  output logic ref_req_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (take_i) pend_q <= 1'b0;
    else             pend_q <= pend_q | tick_i;
  end

  assign ref_req_o = pend_q | tick_i;
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W = 15,
  parameter int unsigned MA_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             acc_ok_i,
  input  logic             area_ok_i,
  input  logic             hit_i,
  input  logic             ref_req_i,
  input  logic             self_ref_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [MA_W-1:0]  col_i,
  input  logic [1:0]       be_i,
  input  logic             we_i,
  output logic             accept_o,
  output logic             take_o,
  output logic [MA_W-1:0]  ma_o,
  output logic             ras_n_o,
  output logic             ucas_n_o,
  output logic             lcas_n_o,
  output logic             we_n_o,
  output logic             rdy_o
);
  dram_st_e st_q, st_d;
  logic     self_q;
  logic     decide;
  logic [1:0] cas_n;

  assign decide   = (st_q == ST_IDLE) || (st_q == ST_OPEN);
  assign take_o   = decide && ref_req_i;
  assign accept_o = decide && !ref_req_i && acc_ok_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (take_o) st_d = ST_RCAS;
                else if (accept_o) st_d = ST_PRE;
      ST_OPEN:  if (take_o) st_d = ST_CLOSE;
                else if (accept_o) st_d = hit_i ? ST_COL : ST_PRE;
      ST_PRE:   st_d = ST_ROW;
      ST_ROW:   st_d = ST_COL;
      ST_COL:   st_d = ST_OPEN;
      ST_CLOSE: st_d = ST_RCAS;
      ST_RCAS:  st_d = ST_RRAS;
      ST_RRAS:  st_d = self_q ? ST_SELF : ST_RPRE;
      ST_SELF:  if (!self_ref_i) st_d = ST_RPRE;
      ST_RPRE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      self_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take_o) self_q <= self_ref_i;
    end
  end

  // per-lane CAS: refresh drives both, column cycle follows byte enables
  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign cas_n[i] = !(((st_q == ST_COL) && be_i[i]) ||
                        (st_q == ST_RCAS) || (st_q == ST_RRAS) || (st_q == ST_SELF));
  end

  assign ras_n_o  = !((st_q == ST_ROW) || (st_q == ST_COL) || (st_q == ST_OPEN) ||
                      (st_q == ST_RRAS) || (st_q == ST_SELF));
  assign ucas_n_o = cas_n[1];
  assign lcas_n_o = cas_n[0];
  assign we_n_o   = !((st_q == ST_COL) && we_i);
  assign rdy_o    = (st_q == ST_COL);
  assign ma_o     = (st_q == ST_ROW) ? row_i[MA_W-1:0] : col_i;

  p_area_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && !area_ok_i && !ref_req_i) |=> ras_n_o);
  p_rdy_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (!ras_n_o && !(ucas_n_o && lcas_n_o)));
  p_we_col_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> rdy_o);
  p_pre_row_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && ucas_n_o && lcas_n_o) |-> $past(ucas_n_o && lcas_n_o));
  p_cbr_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !ucas_n_o) |-> $past(!ucas_n_o && !lcas_n_o));
  p_cbr_ras_next_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ucas_n_o && ras_n_o) |=> !ras_n_o);
  p_post_ref_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_n_o) && $past(!ucas_n_o)) |-> (ucas_n_o && lcas_n_o));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 23,
  parameter int unsigned MA_W    = 10,
  parameter int unsigned AREA_LO = 2,
  parameter int unsigned AREA_HI = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        area_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [1:0]        be_i,
  input  logic [1:0]        col_sel_i,
  input  logic              ref_tick_i,
  input  logic              self_ref_i,
  output logic [MA_W-1:0]   ma_o,
  output logic              ras_n_o,
  output logic              ucas_n_o,
  output logic              lcas_n_o,
  output logic              we_n_o,
  output logic              rdy_o
);
  localparam int unsigned ROW_W = ADDR_W - COL_MIN;

  logic [ROW_W-1:0] row_w, row_q;
  logic [MA_W-1:0]  col_w, col_q;
  logic [1:0]       be_q;
  logic             we_q, hit, accept, take, ref_req, area_ok, acc_ok;

  assign area_ok = (32'(area_i) >= AREA_LO) && (32'(area_i) <= AREA_HI);
  assign acc_ok  = req_i && area_ok && (be_i != 2'b00);

  dram_addr_split #(.ADDR_W(ADDR_W), .MA_W(MA_W)) u_split (
    .addr_i(addr_i), .col_sel_i(col_sel_i), .row_o(row_w), .col_o(col_w)
  );

  dram_page_trk #(.ROW_W(ROW_W), .MA_W(MA_W)) u_page (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept),
    .row_i(row_w), .col_i(col_w), .area_i(area_i), .be_i(be_i), .we_i(we_i),
    .row_o(row_q), .col_o(col_q), .be_o(be_q), .we_o(we_q), .hit_o(hit)
  );

  dram_ref_req u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ref_tick_i), .take_i(take),
    .ref_req_o(ref_req)
  );

  dram_seq #(.ROW_W(ROW_W), .MA_W(MA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .acc_ok_i(acc_ok),
    .area_ok_i(area_ok), .hit_i(hit), .ref_req_i(ref_req),
    .self_ref_i(self_ref_i), .row_i(row_q), .col_i(col_q), .be_i(be_q),
    .we_i(we_q), .accept_o(accept), .take_o(take), .ma_o(ma_o),
    .ras_n_o(ras_n_o), .ucas_n_o(ucas_n_o), .lcas_n_o(lcas_n_o),
    .we_n_o(we_n_o), .rdy_o(rdy_o)
  );
endmodule

// File: tb/dram_ctrl_tb.sv
module dram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, tick = 1'b0, self_r = 1'b0;
  logic [2:0]  area = 3'd2;
  logic [22:0] addr = '0;
  logic [1:0]  be = 2'b11, sel = 2'd0;
  logic [9:0]  ma;
  logic        ras_n, ucas_n, lcas_n, we_n, rdy;

  int vec = 0, bad = 0, cyc = 0;
  string ph = "R12";

  always #5 clk = ~clk;

  dram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .area_i(area), .addr_i(addr),
    .we_i(we), .be_i(be), .col_sel_i(sel), .ref_tick_i(tick),
    .self_ref_i(self_r), .ma_o(ma), .ras_n_o(ras_n), .ucas_n_o(ucas_n),
    .lcas_n_o(lcas_n), .we_n_o(we_n), .rdy_o(rdy)
  );

  typedef struct {
    logic ras, uc, lc, wn, rdy, chk;
    logic [9:0] ma;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  logic m_open, m_self, m_pend;
  logic [14:0] m_row;
  logic [2:0]  m_area;

  function automatic exp_t mk(logic r, logic u, logic l, logic w, logic y,
                              logic c, logic [9:0] a, string t);
    exp_t e;
    e.ras = r; e.uc = u; e.lc = l; e.wn = w; e.rdy = y; e.chk = c; e.ma = a; e.tag = t;
    return e;
  endfunction

  // behavioural reference: queue of per-cycle strobe states
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur = mk(1, 1, 1, 1, 0, 0, '0, "R12");
      m_open = 0; m_self = 0; m_pend = 0; m_row = '0; m_area = '0;
    end else begin
      logic rr, started;
      rr = m_pend | tick;
      started = 0;
      if (q.size() == 0) begin
        if (m_self) begin
          if (self_r) q.push_back(mk(0, 0, 0, 1, 0, 0, '0, "R11"));
          else begin
            q.push_back(mk(1, 1, 1, 1, 0, 0, '0, "R11"));
            q.push_back(mk(1, 1, 1, 1, 0, 0, '0, "R11"));
            m_self = 0;
          end
        end else if (rr) begin
          started = 1;
          if (m_open) q.push_back(mk(1, 1, 1, 1, 0, 0, '0, "R9"));
          q.push_back(mk(1, 0, 0, 1, 0, 0, '0, "R8"));
          q.push_back(mk(0, 0, 0, 1, 0, 0, '0, "R8"));
          if (self_r) begin
            q.push_back(mk(0, 0, 0, 1, 0, 0, '0, "R11"));
            m_self = 1;
          end else begin
            q.push_back(mk(1, 1, 1, 1, 0, 0, '0, "R8"));
            q.push_back(mk(1, 1, 1, 1, 0, 0, '0, "R8"));
          end
          m_open = 0;
        end else if (req && area >= 2 && area <= 5 && be != 2'b00) begin
          int cw;
          logic [22:0] rw, cl;
          cw = (sel == 0) ? 8 : (sel == 1) ? 9 : 10;
          rw = addr >> cw;
          cl = addr & ((23'd1 << cw) - 23'd1);
          if (!(m_open && m_area == area && m_row == rw[14:0])) begin
            q.push_back(mk(1, 1, 1, 1, 0, 0, '0, m_open ? "R7" : "R2"));
            q.push_back(mk(0, 1, 1, 1, 0, 1, rw[9:0], "R3"));
            q.push_back(mk(0, ~be[1], ~be[0], ~we, 1, 1, cl[9:0], "R4/R5"));
          end else
            q.push_back(mk(0, ~be[1], ~be[0], ~we, 1, 1, cl[9:0], "R6"));
          q.push_back(mk(0, 1, 1, 1, 0, 0, '0, "R2"));
          m_open = 1; m_row = rw[14:0]; m_area = area;
        end
      end
      m_pend = started ? 1'b0 : rr;
      if (q.size() != 0) cur = q.pop_front();
      else cur = m_open ? mk(0, 1, 1, 1, 0, 0, '0, ph) : mk(1, 1, 1, 1, 0, 0, '0, ph);
    end
  end

  always @(negedge clk) begin
    vec++;
    if (ras_n !== cur.ras || ucas_n !== cur.uc || lcas_n !== cur.lc ||
        we_n !== cur.wn || rdy !== cur.rdy || (cur.chk && ma !== cur.ma)) begin
      bad++;
      $display("FAIL %s t=%0t ras/ucas/lcas/we/rdy/ma act=%b%b%b%b%b/%h exp=%b%b%b%b%b/%h",
               cur.tag, $time, ras_n, ucas_n, lcas_n, we_n, rdy, ma,
               cur.ras, cur.uc, cur.lc, cur.wn, cur.rdy, cur.ma);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic access(input logic [2:0] a, input logic [22:0] ad, input logic w,
                        input logic [1:0] b, input logic [1:0] s, input string t);
    ph = t; area = a; addr = ad; we = w; be = b; sel = s; req = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rdy) break;
    end
    #1 req = 0;
  endtask

  task automatic pulse_tick();
    tick = 1;
    fork
      begin @(negedge clk); #1 tick = 0; end
    join_none
  endtask

  initial begin
    idle(3);
    rst_n = 1;                                        // R12 checked during/after reset
    idle(2);
    access(3'd2, 23'h01_2345, 0, 2'b11, 2'd0, "R2");  // R2 R3 R4
    access(3'd2, 23'h01_2377, 1, 2'b10, 2'd0, "R6");  // R6 hit, R5 write, R4 upper
    access(3'd2, 23'h01_2301, 0, 2'b01, 2'd0, "R6");  // R4 lower
    access(3'd2, 23'h05_5555, 1, 2'b11, 2'd1, "R7");  // R7 miss, R3 9-bit
    access(3'd3, 23'h05_5555, 0, 2'b11, 2'd1, "R7");  // other area, same row: miss
    ph = "R1"; area = 3'd1; addr = 23'h05_5555; be = 2'b11; req = 1;
    idle(4);
    area = 3'd6; idle(3);
    area = 3'd3; be = 2'b00; idle(3);                 // R4 no enables: ignored
    req = 0;
    access(3'd3, 23'h05_5400, 0, 2'b11, 2'd1, "R1");  // R1 page still open: hit
    ph = "R9"; pulse_tick(); idle(8);                 // R9 close open row then R8
    ph = "R9"; pulse_tick();
    access(3'd4, 23'h7F_FFFF, 0, 2'b11, 2'd2, "R9");  // R9 same cycle from idle, R3 10-bit
    pulse_tick();                                     // R9 same cycle with open row
    access(3'd4, 23'h7F_FC00, 1, 2'b11, 2'd3, "R9");
    ph = "R10"; idle(6);
    ph = "R10"; req = 1; area = 3'd5; addr = 23'h12_3456; be = 2'b11; we = 0; sel = 2'd0;
    idle(1); pulse_tick();                            // R10 tick mid-sequence
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rdy) break;
    end
    #1 req = 0;
    idle(10);
    ph = "R11"; self_r = 1; pulse_tick(); idle(9);    // R11 self-refresh
    self_r = 0; idle(5);
    access(3'd2, 23'h00_0011, 1, 2'b01, 2'd0, "R11");
    idle(4);
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule